// File: doc/BRIEF.md
# Collision, Jabber and Status Controller

This block sits between the attachment-side interface and the twisted-pair side of a 10 Mb/s unit. It decides when the 10 MHz collision signal is sent back toward the attachment interface, and when transmit data must be kept off the cable. It also produces three active-low status lines, for collision, receive and transmit, that are stretched so that they can drive LEDs directly. It takes three digital activity flags. `do_act` means data-out is arriving from the attachment side, `rx_act` means twisted-pair receive data is being passed up, and `sqe_en` enables the heartbeat.

A collision is reported while both directions are active at once. Data-out activity that runs on too long locks the block into jabber. In jabber the collision signal is held on and the transmit path is inhibited, and the block leaves jabber only after a long, unbroken quiet period on data-out. When the heartbeat is enabled, a short burst on the collision pair follows the end of each normal transmission. That burst never lights the collision status. Every timer is a cycle counter whose length is a parameter. The block has no data path, so every pin is a plain level and there is no valid/ready handshake or back-pressure.

Top module: `coljab_ctrl`

## Requirements
- R1: While `do_act` and `rx_act` are both 1, `ci_en` is 1 and `col_led_n` and `rcv_led_n` are 0 in the same cycle.
- R2: After `JAB_CYC` consecutive sampled cycles of `do_act`=1, the block enters jabber from the next cycle. In jabber, `tx_inhibit`=1, `ci_en`=1 and `col_led_n`=0.
- R3: Jabber ends after `UNJAB_CYC` consecutive sampled cycles of `do_act`=0. A sample with `do_act`=1 during that time restarts the count. On release, `ci_en` and `tx_inhibit` drop in the same cycle.
- R4: With `sqe_en`=1, when a sampled `do_act`=1 is followed by a sampled 0 outside jabber, `ci_en` is 1 for `HB_LEN` cycles. These cycles start `HB_DLY` cycles after the first quiet sample's edge plus one cycle. The heartbeat never drives `col_led_n` low.
- R5: No heartbeat is produced when `sqe_en`=0 at the fall, when the block is in jabber, or once `do_act` is sampled 1 again during the delay or the burst.
- R6: Each status output stays asserted (0) for `STRETCH_CYC` cycles after its source condition ends.
- R7: The source for `rcv_led_n` is `rx_act`. The source for `xmt_led_n` is `do_act` outside jabber.
- R8: While `rst_n`=0, all state clears, `ci_en` and `tx_inhibit` are 0 and all three status outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset and power-down |
| do_act | input | 1 | Data-out activity from the attachment side |
| rx_act | input | 1 | Twisted-pair receive activity |
| sqe_en | input | 1 | Heartbeat enable |
| ci_en | output | 1 | Enable for the 10 MHz collision signal |
| tx_inhibit | output | 1 | Keeps data off the twisted-pair transmitter |
| col_led_n | output | 1 | Stretched collision status, active low |
| rcv_led_n | output | 1 | Stretched receive status, active low |
| xmt_led_n | output | 1 | Stretched transmit status, active low |

## Verification
Every output combines the present inputs with registered state. An overlap shows up in the same cycle. The jabber and heartbeat changes appear one edge after the sample that completes their count, and a stretch ends exactly `STRETCH_CYC` edges after its source's last active sample. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. It compares all five outputs on the following falling edge, so each result is checked in the cycle in which it is due, never before or after.

// File: rtl/colj_pkg.sv
package colj_pkg;
  typedef enum logic {ST_NORMAL = 1'b0, ST_JAB = 1'b1} jab_st_t;

  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/colj_jabber.sv
module colj_jabber
  import colj_pkg::*;
#(
  parameter int JAB_CYC   = 5000000,
  parameter int UNJAB_CYC = 50000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_act,
  output logic jab
);
  localparam int MAXC = (JAB_CYC > UNJAB_CYC) ? JAB_CYC : UNJAB_CYC;
  localparam int W    = cnt_w(MAXC);

  jab_st_t       st_q;
  logic [W-1:0]  run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_NORMAL;
      run_q <= '0;
    end else begin
      case (st_q)
        ST_NORMAL: begin
          if (!do_act) run_q <= '0;
          else if (run_q == W'(JAB_CYC - 1)) begin
            st_q  <= ST_JAB;
            run_q <= '0;
          end else run_q <= run_q + W'(1);
        end
        default: begin
          if (do_act) run_q <= '0;
          else if (run_q == W'(UNJAB_CYC - 1)) begin
            st_q  <= ST_NORMAL;
            run_q <= '0;
          end else run_q <= run_q + W'(1);
        end
      endcase
    end
  end

  assign jab = (st_q == ST_JAB);

  a_r2_entry_needs_activity: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jab) |-> $past(do_act));
  a_r3_release_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jab) |-> !$past(do_act));
endmodule

// File: rtl/colj_heartbeat.sv
module colj_heartbeat
  import colj_pkg::*;
#(
  parameter int HB_DLY = 100,
  parameter int HB_LEN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_act,
  input  logic sqe_en,
  input  logic jab,
  output logic hb
);
  localparam int TOT = HB_DLY + HB_LEN;
  localparam int W   = cnt_w(TOT);

  logic [W-1:0] t_q;
  logic         do_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q  <= '0;
      do_q <= 1'b0;
    end else begin
      do_q <= do_act;
      if (do_q && !do_act && !jab && sqe_en) t_q <= W'(1);
      else if (t_q != '0) begin
        if (do_act || jab || t_q == W'(TOT)) t_q <= '0;
        else t_q <= t_q + W'(1);
      end
    end
  end

  assign hb = (t_q > W'(HB_DLY));

  a_r5_no_hb_in_jabber: assert property (@(posedge clk) disable iff (!rst_n)
    hb |-> !jab);
  a_r4_hb_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hb |-> !$past(do_act));
endmodule

// File: rtl/colj_stretch.sv
module colj_stretch
  import colj_pkg::*;
#(
  parameter int HOLD = 4000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  output logic on
);
  localparam int W = cnt_w(HOLD);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (src) cnt_q <= W'(HOLD);
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign on = src || (cnt_q != '0);

  a_r6_hold_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!src && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/coljab_ctrl.sv
module coljab_ctrl
  import colj_pkg::*;
#(
  parameter int JAB_CYC     = 5000000,
  parameter int UNJAB_CYC   = 50000000,
  parameter int STRETCH_CYC = 4000000,
  parameter int HB_DLY      = 100,
  parameter int HB_LEN      = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_act,
  input  logic rx_act,
  input  logic sqe_en,
  output logic ci_en,
  output logic tx_inhibit,
  output logic col_led_n,
  output logic rcv_led_n,
  output logic xmt_led_n
);
  localparam int NLED = 3;

  logic jab, hb, overlap;
  logic [NLED-1:0] led_src, led_on;

  colj_jabber #(.JAB_CYC(JAB_CYC), .UNJAB_CYC(UNJAB_CYC)) u_jab (
    .clk(clk), .rst_n(rst_n), .do_act(do_act), .jab(jab));

  colj_heartbeat #(.HB_DLY(HB_DLY), .HB_LEN(HB_LEN)) u_hb (
    .clk(clk), .rst_n(rst_n), .do_act(do_act), .sqe_en(sqe_en),
    .jab(jab), .hb(hb));

  assign overlap    = do_act && rx_act;
  // index 0: collision, 1: receive, 2: transmit
  assign led_src[0] = overlap || jab;
  assign led_src[1] = rx_act;
  assign led_src[2] = do_act && !jab;

  for (genvar i = 0; i < NLED; i++) begin : g_led
    colj_stretch #(.HOLD(STRETCH_CYC)) u_st (
      .clk(clk), .rst_n(rst_n), .src(led_src[i]), .on(led_on[i]));
  end

  assign ci_en      = rst_n && (overlap || jab || hb);
  assign tx_inhibit = rst_n && jab;
  assign col_led_n  = !(rst_n && led_on[0]);
  assign rcv_led_n  = !(rst_n && led_on[1]);
  assign xmt_led_n  = !(rst_n && led_on[2]);

  a_r1_overlap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |-> (ci_en && !col_led_n && !rcv_led_n));
  a_r2_inhibit_implies_col: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inhibit |-> (ci_en && !col_led_n));
  a_r7_no_xmt_src_in_jab: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inhibit |-> !led_src[2]);

  always_comb begin
    if (!rst_n) begin
      a_r8_reset_quiet: assert (!ci_en && !tx_inhibit && col_led_n && rcv_led_n && xmt_led_n);
    end
  end
endmodule

// File: tb/test_coljab_ctrl.sv
module test_coljab_ctrl;
  localparam int JAB = 40, UNJAB = 60, STR = 10, HD = 3, HL = 4;

  logic clk = 1'b0, rst_n = 1'b0, do_act = 1'b0, rx_act = 1'b0, sqe_en = 1'b0;
  logic ci_en, tx_inhibit, col_led_n, rcv_led_n, xmt_led_n;
  int vectors = 0, errors = 0;

  always #5 clk = ~clk;

  coljab_ctrl #(.JAB_CYC(JAB), .UNJAB_CYC(UNJAB), .STRETCH_CYC(STR),
                .HB_DLY(HD), .HB_LEN(HL)) i_coljab_ctrl (
    .clk(clk), .rst_n(rst_n), .do_act(do_act), .rx_act(rx_act), .sqe_en(sqe_en),
    .ci_en(ci_en), .tx_inhibit(tx_inhibit), .col_led_n(col_led_n),
    .rcv_led_n(rcv_led_n), .xmt_led_n(xmt_led_n));

  // behavioural reference: streak counters and remaining-time counters
  int  busy_streak, quiet_streak, hb_age, hold_col, hold_rcv, hold_xmt;
  bit  m_jab, m_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      busy_streak = 0; quiet_streak = 0; hb_age = 0; m_jab = 0; m_prev = 0;
      hold_col = 0; hold_rcv = 0; hold_xmt = 0;
    end else begin
      bit was_jab;
      was_jab = m_jab;
      hold_col = ((do_act && rx_act) || was_jab) ? STR : (hold_col > 0 ? hold_col - 1 : 0);
      hold_rcv = rx_act ? STR : (hold_rcv > 0 ? hold_rcv - 1 : 0);
      hold_xmt = (do_act && !was_jab) ? STR : (hold_xmt > 0 ? hold_xmt - 1 : 0);
      if (m_prev && !do_act && !was_jab && sqe_en) hb_age = 1;
      else if (hb_age > 0) hb_age = (do_act || was_jab || hb_age == HD + HL) ? 0 : hb_age + 1;
      if (!was_jab) begin
        busy_streak = do_act ? busy_streak + 1 : 0;
        if (busy_streak == JAB) begin m_jab = 1; busy_streak = 0; quiet_streak = 0; end
      end else begin
        quiet_streak = do_act ? 0 : quiet_streak + 1;
        if (quiet_streak == UNJAB) begin m_jab = 0; quiet_streak = 0; busy_streak = 0; end
      end
      m_prev = do_act;
    end
  end

  task automatic cmp(input logic act, input logic exp, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %b expected %b", what, $time, act, exp);
    end
  endtask

  task automatic check_all();
    logic e_ci, e_inh;
    e_ci  = rst_n && ((do_act && rx_act) || m_jab || (hb_age > HD));
    e_inh = rst_n && m_jab;
    cmp(ci_en,      e_ci,  "R1 R2 R3 R4 R5 ci_en");
    cmp(tx_inhibit, e_inh, "R2 R3 tx_inhibit");
    cmp(col_led_n, !(rst_n && ((do_act && rx_act) || m_jab || hold_col > 0)), "R1 R6 col_led_n");
    cmp(rcv_led_n, !(rst_n && (rx_act || hold_rcv > 0)), "R6 R7 rcv_led_n");
    cmp(xmt_led_n, !(rst_n && ((do_act && !m_jab) || hold_xmt > 0)), "R6 R7 xmt_led_n");
    if (!rst_n)
      cmp(ci_en | tx_inhibit | !col_led_n | !rcv_led_n | !xmt_led_n, 1'b0, "R8 reset quiet");
  endtask

  task automatic run(input logic d, input logic r, input logic s, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_all();
      do_act = d; rx_act = r; sqe_en = s;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    run(0, 0, 0, 4);            // R8 held in reset
    rst_n = 1'b1;
    run(0, 0, 0, 3);
    run(1, 1, 0, 5);            // R1 overlap
    run(0, 0, 0, 15);           // R6 stretch
    run(0, 1, 0, 6);            // R7 receive only
    run(0, 0, 0, 14);
    run(1, 0, 1, 8);            // R4 heartbeat after fall
    run(0, 0, 1, 20);
    run(1, 0, 0, 8);            // R5 disabled
    run(0, 0, 0, 16);
    run(1, 0, 1, 6);            // R5 aborted by new activity
    run(0, 0, 1, 2);
    run(1, 0, 1, 3);
    run(0, 0, 1, 20);
    run(1, 0, 1, 50);           // R2 jabber entry
    run(0, 0, 1, 30);           // R5 no heartbeat in jabber
    run(1, 0, 1, 1);            // R3 restart quiet count
    run(0, 0, 1, 75);           // R3 release
    run(1, 1, 0, 45);           // R2 with overlap
    rst_n = 1'b0;
    run(0, 0, 0, 3);            // R8 reset mid-jabber
    rst_n = 1'b1;
    run(0, 0, 0, 15);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule